// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits on the output side of a 12-bit converter data path. By default it forwards each live sample to a 16-bit output bus, placed in the upper twelve bits with zero in the low four bits. A small register set, written from a configuration clock domain, can switch the bus to a test word instead. The test word is either a fixed word (midscale, positive full scale or negative full scale), a two-word pattern (checkerboard or one/zero), or a pair of words programmed from byte registers. A mode field decides whether the bus holds word 1 steadily or swaps between word 1 and word 2 on successive sample cycles.

The configuration registers run on their own clock. Each register update is copied into a hold register and handed to the sample domain through a toggle handshake with two-flop synchronisers. The whole configuration moves as one bundle, so a change of select, mode or user word never yields a word built from part of the old setting and part of the new one. Because of the crossing, the output follows a write only after a few cycles of each clock.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: While rst_ni is low, data_o is 0x0000. After reset the configuration is select 0000, mode 00, with both user words zero, so live samples are forwarded.
- R2: With select 0000 (bits 3:0 of the control byte at address 0xC0), data_o equals {sample_i, 4'b0000} one sample-clock edge after sample_i is presented.
- R3: In static mode (bits 7:6 of 0xC0 = 00), select 0001 drives 0x8000, 0010 drives 0xFFFF and 0011 drives 0x0000 on every sample cycle.
- R4: In alternate mode (bits 7:6 = 01), select 0100 (0xAAAA / 0x5555), 0111 (0xFFFF / 0x0000) and 1000 (user words) place word 1 and word 2 on successive sample cycles.
- R5: In static mode a two-word pattern drives only its word 1, held on every cycle.
- R6: In alternate mode a single-word pattern (selects 0001 to 0011) repeats its one word on every cycle.
- R7: Select 1000 uses user word 1 = {byte at 0xC3, byte at 0xC2} and user word 2 = {byte at 0xC5, byte at 0xC4}.
- R8: Reserved selects 0101, 0110 and 1001 to 1111 forward live samples exactly as R2.
- R9: Mode values 10 and 11 forward live samples exactly as R2, whatever the select.
- R10: While the configuration changes, every word on data_o belongs either to the old configuration or to the new one; no word mixes the two.
- R11: Writes to any address other than 0xC0 and 0xC2 to 0xC5 change nothing on data_o.
- R12: Writes issued back to back, including while an earlier update is still crossing, are not lost: once writing stops, the output reflects the last value written to each register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk_i | input | 1 | Configuration clock |
| smp_clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| cfg_we_i | input | 1 | Register write strobe (configuration domain) |
| cfg_addr_i | input | 8 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| sample_i | input | 12 | Live converter sample (sample domain) |
| data_o | output | 16 | Output word, registered on smp_clk_i |

## Verification
A new configuration can arrive in the sample domain in the same cycle that the alternate-mode phase flips. A register write can also land while the previous bundle is still in flight. The bench provokes the first case by switching between alternating patterns while it watches every output word. Each word must be a member of either the old pattern or the new one. The bench provokes the second case by writing all four user bytes and the control byte in consecutive configuration cycles. It then judges the settled output against the last written values.

// File: rtl/atpg_pkg.sv
`timescale 1ns/1ps
package atpg_pkg;
  localparam int unsigned SAMPLE_W   = 12;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned USER_BYTES = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL      = 8'hC0;
  localparam logic [ADDR_W-1:0] ADDR_USER_BASE = 8'hC2;

  localparam logic [1:0] MODE_STATIC = 2'b00;
  localparam logic [1:0] MODE_ALT    = 2'b01;

  localparam logic [3:0] PAT_OFF     = 4'h0;
  localparam logic [3:0] PAT_MID     = 4'h1;
  localparam logic [3:0] PAT_POS     = 4'h2;
  localparam logic [3:0] PAT_NEG     = 4'h3;
  localparam logic [3:0] PAT_CHECK   = 4'h4;
  localparam logic [3:0] PAT_ONEZERO = 4'h7;
  localparam logic [3:0] PAT_USER    = 4'h8;

  typedef struct packed {
    logic [1:0]        mode;
    logic [3:0]        pat;
    logic [DATA_W-1:0] uw1;
    logic [DATA_W-1:0] uw2;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{mode: MODE_STATIC, pat: PAT_OFF, uw1: '0, uw2: '0};
endpackage

// File: rtl/atpg_regs.sv
`timescale 1ns/1ps
module atpg_regs
  import atpg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output cfg_t              cfg_o,
  output logic              upd_o
);
  logic [1:0] mode_q;
  logic [3:0] pat_q;
  logic [7:0] ubyte_q [USER_BYTES];
  logic [USER_BYTES-1:0] ubyte_hit;
  logic ctrl_hit;

  assign ctrl_hit = we_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STATIC;
      pat_q  <= PAT_OFF;
    end else if (ctrl_hit) begin
      mode_q <= wdata_i[7:6];
      pat_q  <= wdata_i[3:0];
    end
  end

  for (genvar i = 0; i < USER_BYTES; i++) begin : g_ubyte
    assign ubyte_hit[i] = we_i && (addr_i == ADDR_USER_BASE + ADDR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           ubyte_q[i] <= '0;
      else if (ubyte_hit[i]) ubyte_q[i] <= wdata_i;
    end
  end

  assign upd_o = ctrl_hit || (|ubyte_hit);

  always_comb begin
    cfg_o.mode = mode_q;
    cfg_o.pat  = pat_q;
    cfg_o.uw1  = {ubyte_q[1], ubyte_q[0]};
    cfg_o.uw2  = {ubyte_q[3], ubyte_q[2]};
  end

  // R11
  unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |=> (cfg_o == $past(cfg_o)));
endmodule

// File: rtl/atpg_cdc.sv
`timescale 1ns/1ps
module atpg_cdc
  import atpg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic cfg_clk_i,
  input  logic smp_clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_o,
  output logic load_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  // configuration side
  logic req_q, pend_q, ack_s;
  cfg_t hold_q;
  logic [SYNC_STAGES-1:0] ack_sync_q;
  // sample side
  logic [SYNC_STAGES-1:0] req_sync_q;
  logic seen_q;
  cfg_t shadow_q;

  assign ack_s = ack_sync_q[LAST];

  always_ff @(posedge cfg_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      hold_q <= CFG_RESET;
    end else if (pend_q && (req_q == ack_s)) begin
      hold_q <= cfg_i;
      req_q  <= ~req_q;
      pend_q <= upd_i;     // keep a write that lands on the launch edge
    end else if (upd_i) begin
      pend_q <= 1'b1;
    end
  end

  always_ff @(posedge cfg_clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_sync_q <= '0;
    else         ack_sync_q <= {ack_sync_q[SYNC_STAGES-2:0], seen_q};
  end

  assign load_o = req_sync_q[LAST] ^ seen_q;

  always_ff @(posedge smp_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_sync_q <= '0;
      seen_q     <= 1'b0;
      shadow_q   <= CFG_RESET;
    end else begin
      req_sync_q <= {req_sync_q[SYNC_STAGES-2:0], req_q};
      if (load_o) begin
        seen_q   <= req_sync_q[LAST];
        shadow_q <= hold_q;
      end
    end
  end

  assign cfg_o = shadow_q;

  // R10
  hold_stable_chk: assert property (@(posedge cfg_clk_i) disable iff (!rst_ni)
    (req_q != ack_s) |=> ($stable(hold_q) && $stable(req_q)));
  // R10
  load_pulse_chk: assert property (@(posedge smp_clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  // R10
  shadow_on_load_chk: assert property (@(posedge smp_clk_i) disable iff (!rst_ni)
    !load_o |=> $stable(shadow_q));
endmodule

// File: rtl/atpg_gen.sv
`timescale 1ns/1ps
module atpg_gen
  import atpg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  cfg_t                cfg_i,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [DATA_W-1:0]   data_o
);
  localparam int unsigned PAD_W = DATA_W - SAMPLE_W;

  logic [DATA_W-1:0] w1, w2, nxt;
  logic known, two, mode_ok, active, alt, phase_q;

  always_comb begin
    w1 = '0; w2 = '0; two = 1'b0; known = 1'b1;
    case (cfg_i.pat)
      PAT_MID:     w1 = 16'h8000;
      PAT_POS:     w1 = 16'hFFFF;
      PAT_NEG:     w1 = 16'h0000;
      PAT_CHECK:   begin w1 = 16'hAAAA; w2 = 16'h5555; two = 1'b1; end
      PAT_ONEZERO: begin w1 = 16'hFFFF; w2 = 16'h0000; two = 1'b1; end
      PAT_USER:    begin w1 = cfg_i.uw1; w2 = cfg_i.uw2; two = 1'b1; end
      default:     known = 1'b0;
    endcase
  end

  assign mode_ok = (cfg_i.mode == MODE_STATIC) || (cfg_i.mode == MODE_ALT);
  assign active  = known && mode_ok;
  assign alt     = (cfg_i.mode == MODE_ALT) && two;

  always_comb begin
    if (!active)               nxt = {sample_i, {PAD_W{1'b0}}};
    else if (alt && phase_q)   nxt = w2;
    else                       nxt = w1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      data_o  <= '0;
    end else begin
      phase_q <= load_i ? 1'b0 : ~phase_q;
      data_o  <= nxt;
    end
  end

  // R2
  live_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (data_o == {$past(sample_i), {PAD_W{1'b0}}}));
  // R3
  midscale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && cfg_i.pat == PAT_MID) |=> (data_o == 16'h8000));
  // R4
  checker_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.pat == PAT_CHECK && cfg_i.mode == MODE_ALT && !$past(load_i))
      |=> (data_o == ~$past(data_o)));
  // R5
  static_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && cfg_i.mode == MODE_STATIC && !$past(load_i)) |=> $stable(data_o));
endmodule

// File: rtl/adc_test_pattern_gen.sv
`timescale 1ns/1ps
module adc_test_pattern_gen
  import atpg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                cfg_clk_i,
  input  logic                smp_clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [ADDR_W-1:0]   cfg_addr_i,
  input  logic [7:0]          cfg_wdata_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [DATA_W-1:0]   data_o
);
  cfg_t cfg_reg, cfg_smp;
  logic upd, load;

  atpg_regs u_regs (
    .clk_i   (cfg_clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg_reg),
    .upd_o   (upd)
  );

  atpg_cdc #(.SYNC_STAGES(SYNC_STAGES)) u_cdc (
    .cfg_clk_i (cfg_clk_i),
    .smp_clk_i (smp_clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd),
    .cfg_i     (cfg_reg),
    .cfg_o     (cfg_smp),
    .load_o    (load)
  );

  atpg_gen u_gen (
    .clk_i    (smp_clk_i),
    .rst_ni   (rst_ni),
    .cfg_i    (cfg_smp),
    .load_i   (load),
    .sample_i (sample_i),
    .data_o   (data_o)
  );
endmodule

// File: tb/adc_test_pattern_gen_test.sv
`timescale 1ns/1ps
module adc_test_pattern_gen_test;
  logic        cfg_clk = 1'b0, smp_clk = 1'b0, rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [11:0] sample = 12'h123;
  logic [15:0] data_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [15:0] u1 = '0, u2 = '0;

  always #2.0 smp_clk = ~smp_clk;
  always #3.5 cfg_clk = ~cfg_clk;

  adc_test_pattern_gen uut (
    .cfg_clk_i(cfg_clk), .smp_clk_i(smp_clk), .rst_ni(rst_ni),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .sample_i(sample), .data_o(data_o));

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge cfg_clk);
    we = 1'b1; addr = a; wdata = d;
    if (a == 8'hC2) u1[7:0]  = d;
    if (a == 8'hC3) u1[15:8] = d;
    if (a == 8'hC4) u2[7:0]  = d;
    if (a == 8'hC5) u2[15:8] = d;
  endtask

  task automatic wr_end();
    @(negedge cfg_clk);
    we = 1'b0;
  endtask

  task automatic settle();
    repeat (30) @(negedge smp_clk);
  endtask

  // kind: 0 live, 1 constant, 2 alternating
  task automatic model(input logic [7:0] ctrl, output int kind,
                       output logic [15:0] w1, output logic [15:0] w2, output string req);
    logic [1:0] m; logic [3:0] p; bit two;
    m = ctrl[7:6]; p = ctrl[3:0]; w1 = '0; w2 = '0; two = 0; kind = 1;
    case (p)
      4'h1: w1 = 16'h8000;
      4'h2: w1 = 16'hFFFF;
      4'h3: w1 = 16'h0000;
      4'h4: begin w1 = 16'hAAAA; w2 = 16'h5555; two = 1; end
      4'h7: begin w1 = 16'hFFFF; w2 = 16'h0000; two = 1; end
      4'h8: begin w1 = u1; w2 = u2; two = 1; end
      default: kind = 0;
    endcase
    if (m > 2'd1) begin kind = 0; req = "R9"; end
    else if (kind == 0) req = (p == 4'h0) ? "R2" : "R8";
    else if (p == 4'h8) begin req = "R7"; kind = (m == 2'd1) ? 2 : 1; end
    else if (two) begin req = (m == 2'd1) ? "R4" : "R5"; kind = (m == 2'd1) ? 2 : 1; end
    else req = (m == 2'd1) ? "R6" : "R3";
  endtask

  task automatic observe(input logic [7:0] ctrl, input int n);
    int kind; logic [15:0] w1, w2, exp, got, last; string req;
    model(ctrl, kind, w1, w2, req);
    last = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge smp_clk);
      got = data_o;
      if (kind == 0)      exp = {sample, 4'h0};
      else if (kind == 1) exp = w1;
      else if (i == 0)    exp = (got == w2) ? w2 : w1;
      else                exp = (last == w1) ? w2 : w1;
      chk(req, got, exp);
      last = got;
      sample = sample * 12'd13 + 12'd7;
    end
  endtask

  // every word while switching must belong to the old or the new pattern
  task automatic watch_switch(input logic [7:0] from_c, input logic [7:0] to_c);
    int k; logic [15:0] a1, a2, b1, b2, got; string r;
    model(from_c, k, a1, a2, r);
    model(to_c, k, b1, b2, r);
    fork
      begin wr(8'hC0, to_c); wr_end(); end
      for (int i = 0; i < 40; i++) begin
        @(negedge smp_clk);
        got = data_o;
        chk("R10", got, (got == a1 || got == a2 || got == b1 || got == b2) ? got : a1);
      end
    join
  endtask

  initial begin
    repeat (3) @(negedge smp_clk);
    chk("R1", data_o, 16'h0000);
    rst_ni = 1'b1;
    @(negedge smp_clk);
    // R1: reset configuration forwards live data
    observe(8'h00, 8);
    // R1: user words reset to zero
    wr(8'hC0, 8'h48); wr_end(); settle();
    observe(8'h48, 4);
    wr(8'hC0, 8'h00); wr_end(); settle();
    // R2: full sweep of live sample values
    for (int s = 0; s < 4096; s++) begin
      @(negedge smp_clk);
      sample = 12'(s);
      @(negedge smp_clk);
      chk("R2", data_o, {12'(s), 4'h0});
    end
    wr(8'hC2, 8'h34); wr(8'hC3, 8'h12); wr(8'hC4, 8'hCD); wr(8'hC5, 8'hAB); wr_end();
    // R3..R9: every mode against every select
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 16; p++) begin
        logic [7:0] c;
        c = {2'(m), 2'b00, 4'(p)};
        wr(8'hC0, c); wr_end(); settle();
        observe(c, 6);
      end
    end
    // R11: unmapped addresses
    wr(8'hC0, 8'h08); wr_end(); settle();
    wr(8'hC1, 8'h47); wr(8'hC6, 8'h00); wr(8'h40, 8'h44); wr(8'hBF, 8'h00); wr_end(); settle();
    chk("R11", data_o, 16'h1234);
    observe(8'h08, 4);
    // R10: switching between alternating patterns
    wr(8'hC0, 8'h48); wr_end(); settle();
    watch_switch(8'h48, 8'h44);
    watch_switch(8'h44, 8'h47);
    watch_switch(8'h47, 8'h01);
    // R12: back-to-back writes while a transfer is in flight
    wr(8'hC2, 8'h11); wr(8'hC3, 8'h22); wr(8'hC4, 8'h33); wr(8'hC5, 8'h44);
    wr(8'hC0, 8'h02); wr(8'hC0, 8'h48); wr_end(); settle();
    observe(8'h48, 6);
    chk("R12", u1, 16'h2211);
    wr(8'hC0, 8'h08); wr_end(); settle();
    chk("R12", data_o, 16'h2211);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R12 watchdog got running exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule